// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block keeps every in-flight instruction of an out-of-order core in a circular queue, in the order the front end issued them. A dispatch writes a new slot at the tail and hands back the slot index as a tag. The execution units use that tag on one of several completion ports to post a result, and they may mark the instruction as faulting with an exception code. Completions can arrive in any order.

Retirement is strictly in program order. Only the oldest slot can leave the queue, and only after it has completed. A retiring instruction shows its PC, its architectural and physical destinations and its result for one cycle, so that a rename stage can update its map and free registers. A destination of register zero retires without a write enable.

A fault is acted on only when the faulting slot becomes the oldest. At that point the block discards every slot and raises a redirect to a fixed trap vector, together with the faulting PC and code. This gives precise traps.

Top module: `reorder_queue`

## Requirements
- R1: After reset the queue is empty: `disp_ready` is 1, `disp_tag` is 0, and `cmt_valid` and `flush_valid` are 0.
- R2: Each accepted dispatch (`disp_valid` and `disp_ready` both high) returns the current tail index on `disp_tag` in that cycle. The next tag is one higher, modulo DEPTH.
- R3: Once DEPTH instructions are in flight, `disp_ready` is 0 and any dispatch offered is dropped: it takes no slot and no tag. The occupancy never exceeds DEPTH.
- R4: `cmt_valid` rises only for the oldest slot, and only once that slot has completed. Instructions retire one per cycle in dispatch order, whatever the completion order.
- R5: While `cmt_valid` is 1, `cmt_pc`, `cmt_areg`, `cmt_preg` and `cmt_value` show the dispatched PC and destinations of the oldest instruction and its completed result.
- R6: `cmt_wen` is 0 when the retiring destination `cmt_areg` is 0, and 1 for any other destination.
- R7: When the oldest slot has completed with its exception flag set, the block does three things in that cycle: it raises `flush_valid` with `flush_pc` equal to TRAP_VEC, `flush_epc` equal to that slot's PC and `flush_code` equal to its code; it keeps `cmt_valid` at 0; and it discards every slot, so that nothing retires afterwards and the next tag is 0.
- R8: A faulting slot that is not the oldest has no effect until it becomes the oldest. Older slots retire normally before the flush.
- R9: A completion posted in a cycle becomes visible at the next clock edge. An instruction completed while it is the oldest raises `cmt_valid` in the following cycle, not the same one.
- R10: The tail and head indices wrap from DEPTH-1 back to 0 with the retirement order kept.
- R11: All completion ports act in the same cycle, each on its own tag.
- R12: Dispatch is refused (`disp_ready` is 0) in the cycle that `flush_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_pc | input | XLEN | PC of the dispatched instruction |
| disp_areg | input | AREG_W | Architectural destination |
| disp_preg | input | PREG_W | Physical destination |
| disp_ready | output | 1 | Slot available; the dispatch is accepted when both this and `disp_valid` are high |
| disp_tag | output | log2(DEPTH) | Slot index given to this dispatch |
| cpl_valid | input | NUM_CPL | Completion strobe, one per port |
| cpl_tag | input | NUM_CPL*log2(DEPTH) | Slot index, one per port |
| cpl_value | input | NUM_CPL*XLEN | Result, one per port |
| cpl_exc | input | NUM_CPL | Exception flag, one per port |
| cpl_code | input | NUM_CPL*EXC_W | Exception code, one per port |
| cmt_valid | output | 1 | Oldest instruction retires this cycle |
| cmt_pc | output | XLEN | PC of the retiring instruction |
| cmt_areg | output | AREG_W | Its architectural destination |
| cmt_preg | output | PREG_W | Its physical destination |
| cmt_value | output | XLEN | Its result |
| cmt_wen | output | 1 | Register write enable (0 for register zero) |
| flush_valid | output | 1 | Precise trap: all slots discarded |
| flush_pc | output | XLEN | Redirect target (TRAP_VEC) |
| flush_epc | output | XLEN | PC of the faulting instruction |
| flush_code | output | EXC_W | Exception code of the faulting instruction |

## Verification
The bench builds the queue with DEPTH=8, two completion ports, a 32-bit datapath and TRAP_VEC=0x800. With eight slots, a single scenario can fill the queue, try a dispatch that must be refused, and wrap both indices past the top of the queue. The two ports let the bench post completions in reverse order within one cycle. The same build covers a fault at the oldest slot, a fault deeper in the queue that must wait for the older slots to retire, and the one-cycle delay between a completion and the retirement it enables.

// File: rtl/rob_pkg.sv
// Package: shared types for the reorder queue.
// Assumes nothing beyond standard SystemVerilog.
package rob_pkg;
    // State of the oldest slot as seen by the retire logic.
    typedef enum logic [1:0] {
        HEAD_EMPTY  = 2'd0,
        HEAD_WAIT   = 2'd1,
        HEAD_RETIRE = 2'd2,
        HEAD_TRAP   = 2'd3
    } head_state_e;
endpackage

// File: rtl/rob_ptr.sv
// Module: circular index with an extra wrap bit.
// Assumes DEPTH is a power of two, so the increment wraps by itself.
module rob_ptr #(
    parameter int DEPTH = 128
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   adv,
    input  logic                   clr,
    output logic [$clog2(DEPTH):0] ptr
);
    localparam int PW = $clog2(DEPTH) + 1;

    // Step the index, or return it to zero on reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) ptr <= '0;
        else if (adv)      ptr <= PW'(ptr + 1'b1);
    end
endmodule

// File: rtl/rob_store.sv
// Module: slot storage. Dispatch writes the static fields and clears the
// done bit. Completion ports post a result, an exception flag and a code.
// Assumes tags on the completion ports name slots that are in flight;
// when two ports name the same slot, the higher port wins.
module rob_store #(
    parameter int DEPTH   = 128,
    parameter int XLEN    = 32,
    parameter int AREG_W  = 5,
    parameter int PREG_W  = 7,
    parameter int EXC_W   = 4,
    parameter int NUM_CPL = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [$clog2(DEPTH)-1:0]     wr_idx,
    input  logic [XLEN-1:0]              wr_pc,
    input  logic [AREG_W-1:0]            wr_areg,
    input  logic [PREG_W-1:0]            wr_preg,
    input  logic [NUM_CPL-1:0]           cpl_valid,
    input  logic [NUM_CPL*$clog2(DEPTH)-1:0] cpl_tag,
    input  logic [NUM_CPL*XLEN-1:0]      cpl_value,
    input  logic [NUM_CPL-1:0]           cpl_exc,
    input  logic [NUM_CPL*EXC_W-1:0]     cpl_code,
    input  logic                         clr_all,
    input  logic [$clog2(DEPTH)-1:0]     rd_idx,
    output logic [XLEN-1:0]              rd_pc,
    output logic [AREG_W-1:0]            rd_areg,
    output logic [PREG_W-1:0]            rd_preg,
    output logic [XLEN-1:0]              rd_value,
    output logic                         rd_done,
    output logic                         rd_exc,
    output logic [EXC_W-1:0]             rd_code
);
    localparam int IW = $clog2(DEPTH);

    logic [XLEN-1:0]   pc_q    [DEPTH];
    logic [AREG_W-1:0] areg_q  [DEPTH];
    logic [PREG_W-1:0] preg_q  [DEPTH];
    logic [XLEN-1:0]   value_q [DEPTH];
    logic [EXC_W-1:0]  code_q  [DEPTH];
    logic [DEPTH-1:0]  done_q;
    logic [DEPTH-1:0]  exc_q;

    logic [IW-1:0]    p_tag   [NUM_CPL];
    logic [XLEN-1:0]  p_value [NUM_CPL];
    logic [EXC_W-1:0] p_code  [NUM_CPL];

    // Split the flat completion buses into one lane per port.
    for (genvar p = 0; p < NUM_CPL; p++) begin : g_lane
        assign p_tag[p]   = cpl_tag[p*IW +: IW];
        assign p_value[p] = cpl_value[p*XLEN +: XLEN];
        assign p_code[p]  = cpl_code[p*EXC_W +: EXC_W];
    end

    // Capture the static fields of a dispatched instruction.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            pc_q[wr_idx]   <= wr_pc;
            areg_q[wr_idx] <= wr_areg;
            preg_q[wr_idx] <= wr_preg;
        end
    end

    // Capture results and codes posted by the completion ports.
    always_ff @(posedge clk) begin
        for (int p = 0; p < NUM_CPL; p++) begin
            if (cpl_valid[p]) begin
                value_q[p_tag[p]] <= p_value[p];
                code_q[p_tag[p]]  <= p_code[p];
            end
        end
    end

    // Track per-slot done and fault bits; a flush clears them all.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            done_q <= '0;
            exc_q  <= '0;
        end else begin
            if (wr_en) begin
                done_q[wr_idx] <= 1'b0;
                exc_q[wr_idx]  <= 1'b0;
            end
            for (int p = 0; p < NUM_CPL; p++) begin
                if (cpl_valid[p]) begin
                    done_q[p_tag[p]] <= 1'b1;
                    exc_q[p_tag[p]]  <= cpl_exc[p];
                end
            end
        end
    end

    assign rd_pc    = pc_q[rd_idx];
    assign rd_areg  = areg_q[rd_idx];
    assign rd_preg  = preg_q[rd_idx];
    assign rd_value = value_q[rd_idx];
    assign rd_done  = done_q[rd_idx];
    assign rd_exc   = exc_q[rd_idx];
    assign rd_code  = code_q[rd_idx];
endmodule

// File: rtl/rob_retire.sv
// Module: decides what happens to the oldest slot this cycle.
// Assumes its inputs describe the slot under the head index.
module rob_retire #(
    parameter int AREG_W = 5
) (
    input  logic              empty,
    input  logic              head_done,
    input  logic              head_exc,
    input  logic [AREG_W-1:0] head_areg,
    output rob_pkg::head_state_e state,
    output logic              retire,
    output logic              trap,
    output logic              wen
);
    import rob_pkg::*;

    // Classify the oldest slot.
    always_comb begin
        if (empty)           state = HEAD_EMPTY;
        else if (!head_done) state = HEAD_WAIT;
        else if (head_exc)   state = HEAD_TRAP;
        else                 state = HEAD_RETIRE;
    end

    assign retire = (state == HEAD_RETIRE);
    assign trap   = (state == HEAD_TRAP);
    assign wen    = retire && (head_areg != '0);
endmodule

// File: rtl/reorder_queue.sv
// Module: top of the reorder queue. Dispatch in order at the tail, complete
// out of order by tag, retire in order at the head, and trap precisely.
// Assumes DEPTH is a power of two and completions only name live slots.
module reorder_queue #(
    parameter int DEPTH   = 128,
    parameter int XLEN    = 32,
    parameter int AREG_W  = 5,
    parameter int PREG_W  = 7,
    parameter int EXC_W   = 4,
    parameter int NUM_CPL = 2,
    parameter logic [XLEN-1:0] TRAP_VEC = 'h100
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             disp_valid,
    input  logic [XLEN-1:0]                  disp_pc,
    input  logic [AREG_W-1:0]                disp_areg,
    input  logic [PREG_W-1:0]                disp_preg,
    output logic                             disp_ready,
    output logic [$clog2(DEPTH)-1:0]         disp_tag,
    input  logic [NUM_CPL-1:0]               cpl_valid,
    input  logic [NUM_CPL*$clog2(DEPTH)-1:0] cpl_tag,
    input  logic [NUM_CPL*XLEN-1:0]          cpl_value,
    input  logic [NUM_CPL-1:0]               cpl_exc,
    input  logic [NUM_CPL*EXC_W-1:0]         cpl_code,
    output logic                             cmt_valid,
    output logic [XLEN-1:0]                  cmt_pc,
    output logic [AREG_W-1:0]                cmt_areg,
    output logic [PREG_W-1:0]                cmt_preg,
    output logic [XLEN-1:0]                  cmt_value,
    output logic                             cmt_wen,
    output logic                             flush_valid,
    output logic [XLEN-1:0]                  flush_pc,
    output logic [XLEN-1:0]                  flush_epc,
    output logic [EXC_W-1:0]                 flush_code
);
    localparam int IW = $clog2(DEPTH);

    logic [IW:0] head, tail;
    logic        empty, full, accept, retire, trap;
    logic        h_done, h_exc;
    logic [XLEN-1:0]  h_pc;
    logic [EXC_W-1:0] h_code;
    rob_pkg::head_state_e h_state;

    // Equal indices mean empty when the wrap bits match and full when they differ.
    assign empty      = (head == tail);
    assign full       = (head[IW-1:0] == tail[IW-1:0]) && (head[IW] != tail[IW]);
    assign disp_ready = !full && !trap;
    assign accept     = disp_valid && disp_ready;
    assign disp_tag   = tail[IW-1:0];

    rob_ptr #(.DEPTH(DEPTH)) u_tail (
        .clk(clk), .rst_n(rst_n), .adv(accept), .clr(trap), .ptr(tail)
    );

    rob_ptr #(.DEPTH(DEPTH)) u_head (
        .clk(clk), .rst_n(rst_n), .adv(retire), .clr(trap), .ptr(head)
    );

    rob_store #(
        .DEPTH(DEPTH), .XLEN(XLEN), .AREG_W(AREG_W), .PREG_W(PREG_W),
        .EXC_W(EXC_W), .NUM_CPL(NUM_CPL)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(accept), .wr_idx(tail[IW-1:0]),
        .wr_pc(disp_pc), .wr_areg(disp_areg), .wr_preg(disp_preg),
        .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_value(cpl_value),
        .cpl_exc(cpl_exc), .cpl_code(cpl_code),
        .clr_all(trap), .rd_idx(head[IW-1:0]),
        .rd_pc(h_pc), .rd_areg(cmt_areg), .rd_preg(cmt_preg),
        .rd_value(cmt_value), .rd_done(h_done), .rd_exc(h_exc),
        .rd_code(h_code)
    );

    rob_retire #(.AREG_W(AREG_W)) u_retire (
        .empty(empty), .head_done(h_done), .head_exc(h_exc),
        .head_areg(cmt_areg), .state(h_state),
        .retire(retire), .trap(trap), .wen(cmt_wen)
    );

    assign cmt_valid   = retire;
    assign cmt_pc      = h_pc;
    assign flush_valid = trap && (h_state == rob_pkg::HEAD_TRAP);
    assign flush_pc    = TRAP_VEC;
    assign flush_epc   = h_pc;
    assign flush_code  = h_code;
endmodule

// File: rtl/reorder_queue_checker.sv
// Module: property checker for the reorder queue, bound to every instance.
// Keeps its own occupancy count built from port activity only.
module reorder_queue_checker #(
    parameter int DEPTH  = 128,
    parameter int XLEN   = 32,
    parameter int AREG_W = 5,
    parameter logic [XLEN-1:0] TRAP_VEC = 'h100
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     disp_valid,
    input logic                     disp_ready,
    input logic [$clog2(DEPTH)-1:0] disp_tag,
    input logic                     cmt_valid,
    input logic [AREG_W-1:0]        cmt_areg,
    input logic                     cmt_wen,
    input logic                     flush_valid,
    input logic [XLEN-1:0]          flush_pc
);
    localparam int IW = $clog2(DEPTH);
    localparam int OW = IW + 1;

    logic [OW:0] occ;

    // Count live instructions from accepted dispatches, retirements and flushes.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_valid) occ <= '0;
        else occ <= (OW+1)'(occ + (disp_valid && disp_ready) - cmt_valid);
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= (OW+1)'(DEPTH));
    assert_full_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == (OW+1)'(DEPTH)) |-> !disp_ready);
    assert_tag_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_ready) |=> (disp_tag == IW'($past(disp_tag) + 1'b1)));
    assert_empty_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0) |-> (!cmt_valid && !flush_valid));
    assert_one_action_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmt_valid, flush_valid}));
    assert_trap_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> (flush_pc == TRAP_VEC));
    assert_flush_drains_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |=> (!cmt_valid && !flush_valid));
    assert_zero_dest_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_valid && cmt_areg == '0) |-> !cmt_wen);
    assert_live_dest_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_valid && cmt_areg != '0) |-> cmt_wen);
    assert_flush_no_disp_R12: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> !disp_ready);
endmodule

bind reorder_queue reorder_queue_checker #(
    .DEPTH(DEPTH), .XLEN(XLEN), .AREG_W(AREG_W), .TRAP_VEC(TRAP_VEC)
) u_checker (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_tag(disp_tag), .cmt_valid(cmt_valid), .cmt_areg(cmt_areg),
    .cmt_wen(cmt_wen), .flush_valid(flush_valid), .flush_pc(flush_pc)
);

// File: tb/reorder_queue_bench.sv
`timescale 1ns/1ps
// Bench: directed scenarios for the reorder queue, one task each.
module reorder_queue_bench;
    localparam int DEPTH = 8;
    localparam int XLEN  = 32;
    localparam int AW    = 5;
    localparam int PW    = 7;
    localparam int EW    = 4;
    localparam int NC    = 2;
    localparam int IW    = 3;
    localparam logic [31:0] TVEC = 32'h800;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic disp_valid = 1'b0;
    logic [XLEN-1:0] disp_pc = '0;
    logic [AW-1:0] disp_areg = '0;
    logic [PW-1:0] disp_preg = '0;
    logic disp_ready;
    logic [IW-1:0] disp_tag;
    logic [NC-1:0] cpl_valid = '0;
    logic [NC*IW-1:0] cpl_tag = '0;
    logic [NC*XLEN-1:0] cpl_value = '0;
    logic [NC-1:0] cpl_exc = '0;
    logic [NC*EW-1:0] cpl_code = '0;
    logic cmt_valid, cmt_wen, flush_valid;
    logic [XLEN-1:0] cmt_pc, cmt_value, flush_pc, flush_epc;
    logic [AW-1:0] cmt_areg;
    logic [PW-1:0] cmt_preg;
    logic [EW-1:0] flush_code;

    int total = 0;
    int bad = 0;
    logic [IW-1:0] exp_tag = '0;

    always #2.5 clk = ~clk;

    reorder_queue #(
        .DEPTH(DEPTH), .XLEN(XLEN), .AREG_W(AW), .PREG_W(PW),
        .EXC_W(EW), .NUM_CPL(NC), .TRAP_VEC(TVEC)
    ) u_reorder_queue (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_pc(disp_pc), .disp_areg(disp_areg),
        .disp_preg(disp_preg), .disp_ready(disp_ready), .disp_tag(disp_tag),
        .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_value(cpl_value),
        .cpl_exc(cpl_exc), .cpl_code(cpl_code),
        .cmt_valid(cmt_valid), .cmt_pc(cmt_pc), .cmt_areg(cmt_areg),
        .cmt_preg(cmt_preg), .cmt_value(cmt_value), .cmt_wen(cmt_wen),
        .flush_valid(flush_valid), .flush_pc(flush_pc),
        .flush_epc(flush_epc), .flush_code(flush_code)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock: inputs held across the rising edge, then strobes dropped.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        disp_valid = 1'b0;
        cpl_valid  = '0;
        cpl_exc    = '0;
    endtask

    task automatic setc(input int p, input logic [IW-1:0] tag, input logic [31:0] val,
                        input logic exc, input logic [EW-1:0] code);
        cpl_valid[p] = 1'b1;
        cpl_tag[p*IW +: IW] = tag;
        cpl_value[p*XLEN +: XLEN] = val;
        cpl_exc[p] = exc;
        cpl_code[p*EW +: EW] = code;
    endtask

    task automatic disp(input logic [31:0] pc, input logic [AW-1:0] ar,
                        input logic [PW-1:0] pr, output logic [IW-1:0] tag);
        check("R2 R3 ready", 64'(disp_ready), 64'd1);
        check("R2 R10 tag", 64'(disp_tag), 64'(exp_tag));
        tag = disp_tag;
        disp_valid = 1'b1; disp_pc = pc; disp_areg = ar; disp_preg = pr;
        tick();
        exp_tag = IW'(exp_tag + 1'b1);
    endtask

    task automatic expect_commit(input string req, input logic [31:0] pc, input logic [AW-1:0] ar,
                                 input logic [PW-1:0] pr, input logic [31:0] val);
        check({req, " R4 valid"}, 64'(cmt_valid), 64'd1);
        check({req, " R5 pc"}, 64'(cmt_pc), 64'(pc));
        check({req, " R5 areg"}, 64'(cmt_areg), 64'(ar));
        check({req, " R5 preg"}, 64'(cmt_preg), 64'(pr));
        check({req, " R5 value"}, 64'(cmt_value), 64'(val));
        check({req, " R6 wen"}, 64'(cmt_wen), (ar != 0) ? 64'd1 : 64'd0);
        tick();
    endtask

    task automatic t_reset();
        check("R1 ready", 64'(disp_ready), 64'd1);
        check("R1 tag", 64'(disp_tag), 64'd0);
        check("R1 cmt", 64'(cmt_valid), 64'd0);
        check("R1 flush", 64'(flush_valid), 64'd0);
    endtask

    task automatic t_out_of_order();
        logic [IW-1:0] a, b, c;
        disp(32'h100, 5'd1, 7'd10, a);
        disp(32'h104, 5'd2, 7'd11, b);
        disp(32'h108, 5'd3, 7'd12, c);
        setc(0, c, 32'h33, 1'b0, '0);
        setc(1, b, 32'h22, 1'b0, '0);
        tick();
        check("R4 head not done", 64'(cmt_valid), 64'd0);
        setc(0, a, 32'h11, 1'b0, '0);
        tick();
        expect_commit("R11", 32'h100, 5'd1, 7'd10, 32'h11);
        expect_commit("R4", 32'h104, 5'd2, 7'd11, 32'h22);
        expect_commit("R4", 32'h108, 5'd3, 7'd12, 32'h33);
        check("R4 drained", 64'(cmt_valid), 64'd0);
    endtask

    task automatic t_zero_dest();
        logic [IW-1:0] a, b;
        disp(32'h200, 5'd0, 7'd20, a);
        disp(32'h204, 5'd5, 7'd21, b);
        setc(0, a, 32'h44, 1'b0, '0);
        setc(1, b, 32'h55, 1'b0, '0);
        tick();
        expect_commit("R6 x0", 32'h200, 5'd0, 7'd20, 32'h44);
        expect_commit("R6 x5", 32'h204, 5'd5, 7'd21, 32'h55);
    endtask

    task automatic t_timing();
        logic [IW-1:0] a;
        disp(32'h300, 5'd7, 7'd30, a);
        setc(0, a, 32'h66, 1'b0, '0);
        check("R9 not same cycle", 64'(cmt_valid), 64'd0);
        tick();
        expect_commit("R9", 32'h300, 5'd7, 7'd30, 32'h66);
    endtask

    task automatic t_fill_wrap();
        logic [IW-1:0] tg [DEPTH];
        for (int i = 0; i < DEPTH; i++)
            disp(32'h400 + 32'(4*i), AW'(i+1), PW'(40+i), tg[i]);
        check("R3 full", 64'(disp_ready), 64'd0);
        disp_valid = 1'b1; disp_pc = 32'hBAD; disp_areg = 5'd9; disp_preg = 7'd99;
        tick();
        check("R3 still full", 64'(disp_ready), 64'd0);
        for (int i = 1; i < DEPTH; i += 2) begin
            setc(0, tg[i], 32'h500 + 32'(i), 1'b0, '0);
            if (i + 1 < DEPTH) setc(1, tg[i+1], 32'h500 + 32'(i+1), 1'b0, '0);
            tick();
        end
        check("R4 head pending", 64'(cmt_valid), 64'd0);
        setc(0, tg[0], 32'h500, 1'b0, '0);
        tick();
        for (int i = 0; i < DEPTH; i++)
            expect_commit("R10", 32'h400 + 32'(4*i), AW'(i+1), PW'(40+i), 32'h500 + 32'(i));
        check("R3 dropped dispatch", 64'(cmt_valid), 64'd0);
        check("R3 tag unchanged", 64'(disp_tag), 64'(exp_tag));
    endtask

    task automatic t_fault_deep();
        logic [IW-1:0] a, b, c;
        disp(32'h600, 5'd1, 7'd60, a);
        disp(32'h604, 5'd2, 7'd61, b);
        disp(32'h608, 5'd3, 7'd62, c);
        setc(0, b, 32'h0, 1'b1, 4'd5);
        setc(1, c, 32'h77, 1'b0, '0);
        tick();
        check("R8 no commit", 64'(cmt_valid), 64'd0);
        check("R8 no flush", 64'(flush_valid), 64'd0);
        setc(0, a, 32'h88, 1'b0, '0);
        tick();
        check("R8 older first", 64'(flush_valid), 64'd0);
        expect_commit("R8", 32'h600, 5'd1, 7'd60, 32'h88);
        check("R7 flush", 64'(flush_valid), 64'd1);
        check("R7 vector", 64'(flush_pc), 64'(TVEC));
        check("R7 epc", 64'(flush_epc), 64'h604);
        check("R7 code", 64'(flush_code), 64'd5);
        check("R7 no commit", 64'(cmt_valid), 64'd0);
        check("R12 blocked", 64'(disp_ready), 64'd0);
        disp_valid = 1'b1; disp_pc = 32'hBAD; disp_areg = 5'd9; disp_preg = 7'd99;
        tick();
        check("R7 one cycle", 64'(flush_valid), 64'd0);
        check("R7 discarded", 64'(cmt_valid), 64'd0);
        check("R7 tag zero", 64'(disp_tag), 64'd0);
        check("R12 ready after", 64'(disp_ready), 64'd1);
        exp_tag = '0;
    endtask

    task automatic t_fault_head();
        logic [IW-1:0] a;
        disp(32'h700, 5'd4, 7'd70, a);
        setc(1, a, 32'h0, 1'b1, 4'd9);
        tick();
        check("R7 head flush", 64'(flush_valid), 64'd1);
        check("R7 head epc", 64'(flush_epc), 64'h700);
        check("R7 head code", 64'(flush_code), 64'd9);
        check("R7 head no commit", 64'(cmt_valid), 64'd0);
        tick();
        exp_tag = '0;
        disp(32'h710, 5'd6, 7'd71, a);
        setc(0, a, 32'h99, 1'b0, '0);
        tick();
        expect_commit("R7 recover", 32'h710, 5'd6, 7'd71, 32'h99);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_out_of_order();
        t_zero_dest();
        t_timing();
        t_fill_wrap();
        t_fault_deep();
        t_fault_head();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule